// File: doc/BRIEF.md
# CCD Readout Sequencer

This block is the central timing engine of a full-frame CCD camera. From one system clock it generates the two vertical transfer phases, the two horizontal shift phases, and the per-pixel reset, clamp, sample and converter clock strobes. It also produces the frame, line and pixel sync outputs for a frame grabber. A sensor-select code sets the active geometry, meaning pixels per line and lines per frame. A binning code stretches both the pixel period and the vertical pulse train, so that several charge packets are summed on chip before they are digitised.

The block has two operating modes. In still mode it idles until the acquire input falls. It then flushes the array, integrates, and reads out one frame. In free-run mode it skips the flush and repeats integration and readout with no further input. An external exposure timer sets the integration length through a start/done handshake. A diagnostic mode puts the binary line index or a Gray-coded pixel index onto the output data bus in place of converter data, so that frame grabber alignment can be checked.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset every clock, strobe and sync output is low. In still mode the block then idles with `integrate_o` and `frame_o` low until an acquire edge arrives.
- R2: During horizontal transfer the pixel period is 8×B system clocks, where B is the bin factor. The phase p is counted from the pixel's first clock. `rg_o` is high only at p=0. `clamp_o` is high for p=1..3. `sample_o` is high for the last 4 clocks and `adc_clk_o` for the last 3. `pix_o` is high only on the last clock. `h1_o` is high for the first 4 clocks of every 8 and `h2_o` is its complement. All of these outputs are low outside horizontal transfer.
- R3: In still mode a falling edge on `acq_ni` passes two synchroniser flops and an edge detector. The first flush pulse on `v1_o` is high 3 clocks after the input falls. A falling edge that arrives while a flush, integration or readout is running is ignored.
- R4: A flush consists of FLUSH_LINES line cycles. Each line cycle is a `v1_o` pulse followed by a `v2_o` pulse, each VW_PIX×8 clocks wide. Integration follows the flush.
- R5: `integrate_o` is high exactly while the sequencer is integrating. `int_start_o` pulses on the first integration clock. `int_done_i` is honoured from the second integration clock onward. The clock edge that samples it high ends integration and starts vertical transfer on `v1_o`.
- R6: Each binned line begins with a vertical transfer of alternating pulses, each VW_PIX×8 clocks wide. The train starts and ends on `v1_o`, giving B+1 pulses on `v1_o` and B pulses on `v2_o`. The two phases are never high together.
- R7: The 4-bit sensor code selects the raw geometry. Code 0 is 100 pixels by 2 lines, code 2 is 10×4, code 7 is 1000×650 and code 9 is 1200×1150. A frame has ceil(lines/B) lines, and each line has ceil(pixels/B) output pixels.
- R8: The 3-bit bin code maps 1..6 to B=1..6, 7 to B=8 and 0 to B=10. The code and the sensor code are captured when an acquisition or free-run frame begins.
- R9: `line_o` is high for the whole horizontal transfer of each line and low elsewhere. `frame_o` is high from the first vertical transfer of a frame through the end of its last line.
- R10: In free-run mode (`still_i`=0) frames repeat without any acquire input and with no flush pulses.
- R11: With `test_en_i`=1 and `test_sel_i`=0, `data_o` shows the binary line index, starting at 0 for the first line of the frame. With `test_sel_i`=1 it shows the pixel index within the line in Gray code (0,1,3,2,6,7,5,4,12,...). With `test_en_i`=0 it passes `adc_data_i` through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, 8× the unbinned pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| still_i | input | 1 | 1 = still mode, 0 = free-run mode |
| acq_ni | input | 1 | Acquire request, falling edge starts a still capture |
| sensor_i | input | 4 | Sensor geometry select code |
| bin_code_i | input | 3 | Binning select code |
| int_done_i | input | 1 | Exposure timer reports integration complete |
| test_en_i | input | 1 | Enables the sync diagnostic on the data bus |
| test_sel_i | input | 1 | Diagnostic select: 0 = line index, 1 = Gray pixel index |
| adc_data_i | input | DATA_W | Converter output word |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| rg_o | output | 1 | Output-node reset gate pulse |
| clamp_o | output | 1 | CDS clamp strobe |
| sample_o | output | 1 | CDS sample strobe |
| adc_clk_o | output | 1 | Converter clock |
| pix_o | output | 1 | Pixel sync, one clock per output pixel |
| line_o | output | 1 | Line sync, high during horizontal transfer |
| frame_o | output | 1 | Frame sync, high across readout |
| integrate_o | output | 1 | High during integration |
| int_start_o | output | 1 | One-clock start pulse to the exposure timer |
| data_o | output | DATA_W | Converter data or diagnostic counter |

## Verification
Every output is decoded from registered state, so a result appears at the falling edge that follows the rising edge that produced it. The bench samples only on falling edges.

Acquire takes three edges to reach `v1_o`, and the bench counts exactly three falling edges from the input drop. A `int_done_i` raised at a falling edge inside integration is checked at the next falling edge, where `integrate_o` must already be low and `v1_o` high.

Pixel strobe offsets are checked against a phase counter that the bench restarts on the first high cycle of `line_o`. Diagnostic data is compared on the `pix_o` clock, which is the last clock before the pixel index advances.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

    typedef enum logic [3:0] {
        ST_CLEAR = 4'd0,
        ST_SETUP = 4'd1,
        ST_MODE  = 4'd2,
        ST_WAIT  = 4'd3,
        ST_FLUSH = 4'd4,
        ST_INTEG = 4'd5,
        ST_VXFER = 4'd6,
        ST_HXFER = 4'd7,
        ST_LCHK  = 4'd8
    } seq_state_e;

    function automatic logic [15:0] to_gray(input logic [15:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/ccd_acq_sync.sv
module ccd_acq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic acq_ni,
    output logic fall_o
);
    logic [STAGES:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-1:0], acq_ni};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= chain_d;
    end

    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

    a_r3_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ccd_geom_lut.sv
module ccd_geom_lut #(
    parameter int GEO_W = 13,
    parameter int BIN_W = 4
) (
    input  logic [3:0]       sensor_i,
    input  logic [2:0]       bin_code_i,
    output logic [GEO_W-1:0] npix_o,
    output logic [GEO_W-1:0] nline_o,
    output logic [BIN_W-1:0] bin_o
);
    always_comb begin
        unique case (sensor_i)
            4'h0: begin npix_o = GEO_W'(100);  nline_o = GEO_W'(2);    end
            4'h1: begin npix_o = GEO_W'(1500); nline_o = GEO_W'(1200); end
            4'h2: begin npix_o = GEO_W'(10);   nline_o = GEO_W'(4);    end
            4'h3: begin npix_o = GEO_W'(1500); nline_o = GEO_W'(1200); end
            4'h4: begin npix_o = GEO_W'(2300); nline_o = GEO_W'(2150); end
            4'h5: begin npix_o = GEO_W'(1700); nline_o = GEO_W'(1100); end
            4'h6: begin npix_o = GEO_W'(3300); nline_o = GEO_W'(2150); end
            4'h7: begin npix_o = GEO_W'(1000); nline_o = GEO_W'(650);  end
            4'h8: begin npix_o = GEO_W'(2300); nline_o = GEO_W'(1600); end
            4'h9: begin npix_o = GEO_W'(1200); nline_o = GEO_W'(1150); end
            4'hA: begin npix_o = GEO_W'(700);  nline_o = GEO_W'(650);  end
            4'hB: begin npix_o = GEO_W'(4300); nline_o = GEO_W'(4200); end
            4'hC: begin npix_o = GEO_W'(2300); nline_o = GEO_W'(2200); end
            default: begin npix_o = GEO_W'(16); nline_o = GEO_W'(8);   end
        endcase
    end

    always_comb begin
        unique case (bin_code_i)
            3'd0:    bin_o = BIN_W'(10);
            3'd7:    bin_o = BIN_W'(8);
            default: bin_o = BIN_W'(bin_code_i);
        endcase
    end
endmodule

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
    parameter int PIX_CLKS   = 8,
    parameter int BIN_W      = 4,
    parameter int CLAMP_LEN  = 3,
    parameter int SAMPLE_LEN = 4,
    parameter int ADC_LEN    = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [BIN_W-1:0] bin_i,
    output logic             h1_o,
    output logic             h2_o,
    output logic             rg_o,
    output logic             clamp_o,
    output logic             sample_o,
    output logic             adc_o,
    output logic             pix_o
);
    localparam int PER_W = $clog2(PIX_CLKS * (2 ** BIN_W));
    localparam int SUB_W = (PIX_CLKS > 2) ? $clog2(PIX_CLKS) : 1;
    localparam int HALF  = PIX_CLKS / 2;

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] ph_d, ph_q;
    logic [SUB_W-1:0] sub_d, sub_q;

    assign period = PER_W'(PIX_CLKS) * PER_W'(bin_i);

    always_comb begin
        ph_d  = '0;
        sub_d = '0;
        if (run_i) begin
            ph_d  = (ph_q == period - PER_W'(1)) ? '0 : ph_q + PER_W'(1);
            sub_d = (sub_q == SUB_W'(PIX_CLKS - 1)) ? '0 : sub_q + SUB_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ph_q  <= '0;
            sub_q <= '0;
        end else begin
            ph_q  <= ph_d;
            sub_q <= sub_d;
        end
    end

    assign rg_o     = run_i && (ph_q == '0);
    assign clamp_o  = run_i && (ph_q >= PER_W'(1)) && (ph_q <= PER_W'(CLAMP_LEN));
    assign sample_o = run_i && (ph_q >= period - PER_W'(SAMPLE_LEN));
    assign adc_o    = run_i && (ph_q >= period - PER_W'(ADC_LEN));
    assign pix_o    = run_i && (ph_q == period - PER_W'(1));
    assign h1_o     = run_i && (sub_q < SUB_W'(HALF));
    assign h2_o     = run_i && (sub_q >= SUB_W'(HALF));

    a_r2_reset_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rg_o |=> !rg_o);
    a_r2_clamp_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clamp_o) |-> $past(rg_o));
    a_r2_pix_in_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_o |-> (sample_o && adc_o));
endmodule

// File: rtl/ccd_gray_cnt.sv
module ccd_gray_cnt #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] gray_o
);
    logic [W-1:0] g_d, g_q;
    logic [W-1:0] bin_now;

    always_comb begin
        bin_now[W-1] = g_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_now[i] = bin_now[i+1] ^ g_q[i];
        end
    end

    always_comb begin
        g_d = g_q;
        if (clr_i)      g_d = '0;
        else if (inc_i) g_d = (bin_now + W'(1)) ^ ((bin_now + W'(1)) >> 1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) g_q <= '0;
        else         g_q <= g_d;
    end

    assign gray_o = g_q;

    a_r11_gray_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ($countones(g_q ^ $past(g_q)) <= 1));
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
    import ccd_seq_pkg::*;
#(
    parameter int PIX_CLKS    = 8,
    parameter int VW_PIX      = 64,
    parameter int FLUSH_LINES = 4000,
    parameter int DATA_W      = 12,
    parameter int GEO_W       = 13,
    parameter int BIN_W       = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              still_i,
    input  logic              acq_ni,
    input  logic [3:0]        sensor_i,
    input  logic [2:0]        bin_code_i,
    input  logic              int_done_i,
    input  logic              test_en_i,
    input  logic              test_sel_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              v1_o,
    output logic              v2_o,
    output logic              h1_o,
    output logic              h2_o,
    output logic              rg_o,
    output logic              clamp_o,
    output logic              sample_o,
    output logic              adc_clk_o,
    output logic              pix_o,
    output logic              line_o,
    output logic              frame_o,
    output logic              integrate_o,
    output logic              int_start_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int VW_CLKS = VW_PIX * PIX_CLKS;
    localparam int SEG_W   = $clog2(VW_CLKS);
    localparam int FL_W    = $clog2(FLUSH_LINES + 1);
    localparam int SIDX_W  = BIN_W + 1;

    typedef struct packed {
        seq_state_e        st;
        logic [SEG_W-1:0]  seg_cnt;
        logic [SIDX_W-1:0] seg_idx;
        logic [FL_W-1:0]   flush_cnt;
        logic [GEO_W-1:0]  raw_px;
        logic [GEO_W-1:0]  raw_ln;
        logic [DATA_W-1:0] line_idx;
        logic              int_first;
        logic [3:0]        sensor;
        logic [2:0]        bcode;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              acq_fall;
    logic [GEO_W-1:0]  npix, nline;
    logic [BIN_W-1:0]  bin;
    logic              hx_run, px_end;
    logic [DATA_W-1:0] gray_px;
    logic              seg_last;

    ccd_acq_sync #(.STAGES(2)) u_sync (
        .clk_i (clk_i), .rst_ni(rst_ni), .acq_ni(acq_ni), .fall_o(acq_fall)
    );

    ccd_geom_lut #(.GEO_W(GEO_W), .BIN_W(BIN_W)) u_geom (
        .sensor_i(r_q.sensor), .bin_code_i(r_q.bcode),
        .npix_o(npix), .nline_o(nline), .bin_o(bin)
    );

    assign hx_run = (r_q.st == ST_HXFER);

    ccd_pix_timer #(.PIX_CLKS(PIX_CLKS), .BIN_W(BIN_W)) u_pix (
        .clk_i(clk_i), .rst_ni(rst_ni), .run_i(hx_run), .bin_i(bin),
        .h1_o(h1_o), .h2_o(h2_o), .rg_o(rg_o), .clamp_o(clamp_o),
        .sample_o(sample_o), .adc_o(adc_clk_o), .pix_o(px_end)
    );

    ccd_gray_cnt #(.W(DATA_W)) u_gray (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!hx_run), .inc_i(px_end),
        .gray_o(gray_px)
    );

    assign seg_last = (r_q.seg_cnt == SEG_W'(VW_CLKS - 1));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_CLEAR: begin
                r_d    = '0;
                r_d.st = ST_SETUP;
            end
            ST_SETUP: begin
                r_d.seg_cnt   = '0;
                r_d.seg_idx   = '0;
                r_d.flush_cnt = '0;
                r_d.st        = ST_MODE;
            end
            ST_MODE: begin
                if (still_i) begin
                    r_d.st = ST_WAIT;
                end else begin
                    r_d.sensor    = sensor_i;
                    r_d.bcode     = bin_code_i;
                    r_d.int_first = 1'b1;
                    r_d.st        = ST_INTEG;
                end
            end
            ST_WAIT: begin
                if (acq_fall) begin
                    r_d.sensor    = sensor_i;
                    r_d.bcode     = bin_code_i;
                    r_d.seg_cnt   = '0;
                    r_d.seg_idx   = '0;
                    r_d.flush_cnt = '0;
                    r_d.st        = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                r_d.seg_cnt = r_q.seg_cnt + SEG_W'(1);
                if (seg_last) begin
                    r_d.seg_cnt = '0;
                    if (r_q.seg_idx[0]) begin
                        r_d.seg_idx = '0;
                        if (r_q.flush_cnt == FL_W'(FLUSH_LINES - 1)) begin
                            r_d.int_first = 1'b1;
                            r_d.st        = ST_INTEG;
                        end else begin
                            r_d.flush_cnt = r_q.flush_cnt + FL_W'(1);
                        end
                    end else begin
                        r_d.seg_idx = SIDX_W'(1);
                    end
                end
            end
            ST_INTEG: begin
                r_d.int_first = 1'b0;
                r_d.raw_ln    = '0;
                r_d.line_idx  = '0;
                r_d.seg_cnt   = '0;
                r_d.seg_idx   = '0;
                if (!r_q.int_first && int_done_i) r_d.st = ST_VXFER;
            end
            ST_VXFER: begin
                r_d.seg_cnt = r_q.seg_cnt + SEG_W'(1);
                if (seg_last) begin
                    r_d.seg_cnt = '0;
                    if (r_q.seg_idx == {bin, 1'b0}) begin
                        r_d.seg_idx = '0;
                        r_d.raw_px  = '0;
                        r_d.st      = ST_HXFER;
                    end else begin
                        r_d.seg_idx = r_q.seg_idx + SIDX_W'(1);
                    end
                end
            end
            ST_HXFER: begin
                if (px_end) begin
                    r_d.raw_px = r_q.raw_px + GEO_W'(bin);
                    if (r_q.raw_px + GEO_W'(bin) >= npix) r_d.st = ST_LCHK;
                end
            end
            ST_LCHK: begin
                r_d.line_idx = r_q.line_idx + DATA_W'(1);
                r_d.raw_ln   = r_q.raw_ln + GEO_W'(bin);
                if (r_q.raw_ln + GEO_W'(bin) >= nline) r_d.st = ST_MODE;
                else                                    r_d.st = ST_VXFER;
            end
            default: r_d.st = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    logic v_active;
    assign v_active    = (r_q.st == ST_FLUSH) || (r_q.st == ST_VXFER);
    assign v1_o        = v_active && !r_q.seg_idx[0];
    assign v2_o        = v_active &&  r_q.seg_idx[0];
    assign pix_o       = px_end;
    assign line_o      = hx_run;
    assign frame_o     = (r_q.st == ST_VXFER) || (r_q.st == ST_HXFER) || (r_q.st == ST_LCHK);
    assign integrate_o = (r_q.st == ST_INTEG);
    assign int_start_o = integrate_o && r_q.int_first;
    assign data_o      = !test_en_i ? adc_data_i : (test_sel_i ? gray_px : r_q.line_idx);

    a_r5_start_inside_integ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_start_o |-> integrate_o);
    a_r5_rise_gives_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(integrate_o) |-> int_start_o);
    a_r6_phase_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(v1_o && v2_o));
    a_r9_line_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_o |-> frame_o);
    a_r2_h_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_o |-> (h1_o ^ h2_o));
    a_r3_flush_from_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((r_q.st == ST_FLUSH) && ($past(r_q.st) != ST_FLUSH)) |-> ($past(r_q.st) == ST_WAIT));
    a_r4_flush_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.flush_cnt < FL_W'(FLUSH_LINES));
endmodule

// File: tb/ccd_readout_seq_bench.sv
module ccd_readout_seq_bench;
    localparam int DW = 12;
    localparam int VWP = 2;
    localparam int FL = 3;
    localparam int W = VWP * 8;
    localparam int NV = 5;
    localparam int WD_LIMIT = 150000;
    localparam logic [DW-1:0] ADC_WORD = 12'hA5C;

    // vector table: bin code, expected bin, pixels/line, lines/frame, diag mode (0 off,1 line,2 gray)
    localparam int V_CODE [NV] = '{1, 2, 3, 7, 0};
    localparam int V_BIN  [NV] = '{1, 2, 3, 8, 10};
    localparam int V_PX   [NV] = '{10, 5, 4, 2, 1};
    localparam int V_LN   [NV] = '{4, 2, 2, 1, 1};
    localparam int V_TM   [NV] = '{2, 1, 0, 2, 1};

    logic clk = 0, rst_n = 0, still = 1, acq_n = 1, int_done = 0, test_en = 0, test_sel = 0;
    logic [3:0] sensor = 4'd2;
    logic [2:0] bin_code = 3'd1;
    logic [DW-1:0] adc = ADC_WORD;
    logic v1, v2, h1, h2, rg, clamp, sample, adcclk, pix, line, frame, integ, int_start;
    logic [DW-1:0] data;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ccd_readout_seq #(.VW_PIX(VWP), .FLUSH_LINES(FL)) u_ccd_readout_seq (
        .clk_i(clk), .rst_ni(rst_n), .still_i(still), .acq_ni(acq_n), .sensor_i(sensor),
        .bin_code_i(bin_code), .int_done_i(int_done), .test_en_i(test_en), .test_sel_i(test_sel),
        .adc_data_i(adc), .v1_o(v1), .v2_o(v2), .h1_o(h1), .h2_o(h2), .rg_o(rg), .clamp_o(clamp),
        .sample_o(sample), .adc_clk_o(adcclk), .pix_o(pix), .line_o(line), .frame_o(frame),
        .integrate_o(integ), .int_start_o(int_start), .data_o(data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor
    bit mon_en = 0;
    int tmode = 0, per = 8;
    int m_v1r, m_v2r, m_v1h, m_fv1r, m_pix, m_liner, m_lineh, m_rst, m_samp, m_bad, m_dbad, m_ints, m_frr;
    int lc, cur_line, cur_pix, ph, sb;
    logic p_v1 = 0, p_v2 = 0, p_line = 0, p_frame = 0;

    task automatic mon_clear();
        m_v1r = 0; m_v2r = 0; m_v1h = 0; m_fv1r = 0; m_pix = 0; m_liner = 0; m_lineh = 0;
        m_rst = 0; m_samp = 0; m_bad = 0; m_dbad = 0; m_ints = 0; m_frr = 0;
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (v1 && !p_v1) begin if (frame) m_v1r++; else m_fv1r++; end
            if (v2 && !p_v2 && frame) m_v2r++;
            if (v1 && frame) m_v1h++;
            if (frame && !p_frame) m_frr++;
            if (int_start) m_ints++;
            if (line) begin
                if (!p_line) begin lc = 0; m_liner++; cur_line = m_liner - 1; cur_pix = 0; end
                else lc++;
                m_lineh++;
                ph = lc % per; sb = lc % 8;
                if (rg != (ph == 0)) m_bad++;
                if (clamp != (ph >= 1 && ph <= 3)) m_bad++;
                if (sample != (ph >= per - 4)) m_bad++;
                if (adcclk != (ph >= per - 3)) m_bad++;
                if (pix != (ph == per - 1)) m_bad++;
                if (h1 != (sb < 4) || h2 != (sb >= 4)) m_bad++;
                if (rg) m_rst++;
                if (sample) m_samp++;
                if (pix) begin
                    m_pix++;
                    if (tmode == 1 && data != DW'(cur_line)) m_dbad++;
                    if (tmode == 2 && data != DW'(cur_pix ^ (cur_pix >> 1))) m_dbad++;
                    if (tmode == 0 && data != ADC_WORD) m_dbad++;
                    cur_pix++;
                end
            end else if (rg || clamp || sample || adcclk || pix || h1 || h2) m_bad++;
        end
        p_v1 = v1; p_v2 = v2; p_line = line; p_frame = frame;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wait_start();
        do @(negedge clk); while (!int_start);
    endtask

    task automatic end_integ(input bit check);
        repeat (4) @(negedge clk);
        int_done = 1;
        @(negedge clk);
        if (check) chk(!integ && v1, "R5 done ends integration, V1 starts", {integ, v1}, 1);
        int_done = 0;
    endtask

    task automatic wait_frame_end();
        do @(negedge clk); while (!frame);
        do @(negedge clk); while (frame);
    endtask

    task automatic run_vec(input int i);
        int n;
        @(negedge clk);
        bin_code = 3'(V_CODE[i]);
        test_en  = (V_TM[i] != 0);
        test_sel = (V_TM[i] == 2);
        tmode    = V_TM[i];
        per      = 8 * V_BIN[i];
        mon_clear();
        mon_en = 1;
        acq_n = 0;
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 2) acq_n = 1;
        end while (!v1 && n < 50);
        chk(n == 3, "R3 acquire to first flush pulse latency", n, 3);
        wait_start();
        chk(m_fv1r == FL, "R4 flush V1 pulse count", m_fv1r, FL);
        chk(integ, "R5 integrate high at start pulse", integ, 1);
        end_integ(1'b1);
        // acquire during readout must be ignored
        acq_n = 0; repeat (3) @(negedge clk); acq_n = 1;
        wait_frame_end();
        repeat (300) @(negedge clk);
        mon_en = 0;
        chk(m_ints == 1 && m_frr == 1, "R3 acquire during readout ignored", m_ints * 10 + m_frr, 11);
        chk(m_liner == V_LN[i], "R7 lines per frame", m_liner, V_LN[i]);
        chk(m_pix == V_LN[i] * V_PX[i], "R7 pixels per frame", m_pix, V_LN[i] * V_PX[i]);
        chk(m_lineh == V_LN[i] * V_PX[i] * per, "R2 R9 line active cycles", m_lineh, V_LN[i] * V_PX[i] * per);
        chk(m_v1r == V_LN[i] * (V_BIN[i] + 1), "R6 R8 V1 pulses", m_v1r, V_LN[i] * (V_BIN[i] + 1));
        chk(m_v2r == V_LN[i] * V_BIN[i], "R6 R8 V2 pulses", m_v2r, V_LN[i] * V_BIN[i]);
        chk(m_v1h == V_LN[i] * (V_BIN[i] + 1) * W, "R6 V1 pulse width", m_v1h, V_LN[i] * (V_BIN[i] + 1) * W);
        chk(m_rst == V_LN[i] * V_PX[i], "R2 reset pulses", m_rst, V_LN[i] * V_PX[i]);
        chk(m_samp == V_LN[i] * V_PX[i] * 4, "R2 sample cycles", m_samp, V_LN[i] * V_PX[i] * 4);
        chk(m_bad == 0, "R2 pixel strobe offsets", m_bad, 0);
        chk(m_dbad == 0, "R11 data bus content", m_dbad, 0);
    endtask

    initial begin
        mon_clear();
        repeat (3) @(negedge clk);
        chk({v1, v2, h1, h2, rg, clamp, sample, adcclk, pix, line, frame, integ, int_start} == '0,
            "R1 outputs low in reset", 1, 0);
        rst_n = 1;
        repeat (10) @(negedge clk);
        chk(!integ && !frame && !v1 && !v2, "R1 idle after reset in still mode", {integ, frame}, 0);
        chk(data == ADC_WORD, "R11 converter data passes when diag off", int'(data), int'(ADC_WORD));

        for (int i = 0; i < NV; i++) run_vec(i);

        // R10: free-run with sensor code 0 (100 x 2), unbinned
        @(negedge clk);
        rst_n = 0; still = 0; sensor = 4'd0; bin_code = 3'd1; test_en = 0; tmode = 0; per = 8;
        repeat (2) @(negedge clk);
        mon_clear();
        mon_en = 1;
        rst_n = 1;
        for (int f = 0; f < 2; f++) begin
            wait_start();
            end_integ(1'b0);
            wait_frame_end();
        end
        mon_en = 0;
        chk(m_fv1r == 0, "R10 no flush in free-run", m_fv1r, 0);
        chk(m_ints == 2 && m_frr == 2, "R10 frames repeat without acquire", m_ints * 10 + m_frr, 22);
        chk(m_pix == 400, "R7 sensor code 0 geometry", m_pix, 400);
        chk(m_liner == 4, "R7 sensor code 0 lines", m_liner, 4);
        chk(m_bad == 0, "R2 strobes in free-run", m_bad, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule